// File: doc/BRIEF.md
# Two-Wire Controller Status Flags

This block keeps the read-only status word of a two-wire serial controller that can act as bus master or as slave. The bus engine reports what happens on the wire through one-cycle event strobes: START seen, STOP seen, a repeated START whose address is not ours, a byte moved from the holding register into the shifter, a byte received, a NACK, and STOP sent by the master. The register interface reports its own strobes: a write of the transmit holding register, a read of the receive holding register, a read of the status word, and the assertion of master enable. From these strobes the block maintains four flags: transmit complete, receive ready, transmit ready and NACK.

Every flag is a registered bit. It changes on the clock edge that samples its strobe, so the new value is visible one cycle after the strobe. The role input selects which rule set drives transmit complete and transmit ready. Rules that belong to one role are ignored while the other role is active. No data moves through this block, so every pin is a plain level or a one-cycle strobe, and there is no valid/ready handshake.

Top module: `twsf_status`

## Requirements
- R1: A synchronous reset sets the 32-bit status word to 0x0000F009. Bit 0 is transmit complete, bit 1 is receive ready, bit 2 is transmit ready and bit 8 is NACK. Bits 3 and 12 to 15 stay at 1 and every other bit stays at 0 at all times.
- R2: In master role, a START strobe clears transmit complete, and it stays low for the rest of the frame.
- R3: In master role, a STOP-sent strobe sets transmit complete only when transmit ready is already 1 (holding register empty) and the shifter-empty input is 1. Otherwise the strobe leaves the flag unchanged.
- R4: In slave role, a START strobe clears transmit complete.
- R5: In slave role, a STOP strobe or a foreign-address repeated-START strobe sets transmit complete. This set wins over a START strobe in the same cycle.
- R6: A received byte sets receive ready, and a read of the receive holding register clears it. When both happen in the same cycle, the set wins.
- R7: In master role, a write of the transmit holding register clears transmit ready, and a holding-to-shifter move sets it. When both happen in the same cycle, the set wins.
- R8: A NACK strobe sets the NACK flag and transmit ready on the same edge. In master role it also sets transmit complete on that edge.
- R9: Master enable sets transmit ready in either role.
- R10: A status read clears the NACK flag, unless a NACK strobe arrives in the same cycle. A status read changes no other flag.
- R11: Role-specific strobes are ignored in the other role. In slave role, holding-register writes, holding-to-shifter moves and STOP-sent leave transmit ready and transmit complete unchanged. In master role, STOP and foreign repeated-START leave transmit complete unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| is_master | input | 1 | 1 selects the master role, 0 selects the slave role |
| bus_start | input | 1 | START detected on the bus |
| bus_stop | input | 1 | STOP detected on the bus |
| bus_rstart_foreign | input | 1 | Repeated START followed by an address other than ours |
| hold_to_shift | input | 1 | Byte moved from the holding register into the shifter |
| byte_rcvd | input | 1 | Byte placed in the receive holding register |
| nack_seen | input | 1 | NACK detected |
| stop_sent | input | 1 | Master finished sending STOP |
| shift_empty | input | 1 | Transmit shifter holds no data |
| thr_write | input | 1 | Write of the transmit holding register |
| rhr_read | input | 1 | Read of the receive holding register |
| sr_read | input | 1 | Read of the status word |
| master_enable | input | 1 | Master enable asserted |
| status | output | 32 | Status word |

## Verification
The bench targets the same-cycle collisions:
- **Set and clear together.** If the clear won instead of the set, a received byte would be lost under a concurrent read, or a NACK would vanish under a concurrent status read.
- **STOP-sent gating.** A design that ignored the holding or shifter condition would report the frame complete while data was still queued.
- **Role leakage.** A design whose role rules leaked would let a slave-side STOP end a master frame, or let a holding-register write in slave role drop transmit ready.
- **Status read side effects.** A status read is checked to leave receive ready, transmit ready and transmit complete exactly as they were.

// File: rtl/twsf_pkg.sv
package twsf_pkg;
  localparam int STAT_W = 32;
  localparam int TC_BIT = 0;
  localparam int RX_BIT = 1;
  localparam int TR_BIT = 2;
  localparam int NK_BIT = 8;
  localparam logic [STAT_W-1:0] RESET_WORD = 32'h0000_F009;
  // bits owned by this block; the rest are held at RESET_WORD
  localparam logic [STAT_W-1:0] OWNED_MASK =
    (32'd1 << TC_BIT) | (32'd1 << RX_BIT) | (32'd1 << TR_BIT) | (32'd1 << NK_BIT);
endpackage

// File: rtl/twsf_flag.sv
// One sticky status bit: set dominates clear, synchronous reset.
module twsf_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= RST_VAL;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/twsf_txcomp_rules.sv
// Role-dependent set/clear terms for transmit complete and transmit ready.
module twsf_txcomp_rules (
  input  logic is_master,
  input  logic bus_start,
  input  logic bus_stop,
  input  logic bus_rstart_foreign,
  input  logic hold_to_shift,
  input  logic nack_seen,
  input  logic stop_sent,
  input  logic shift_empty,
  input  logic thr_write,
  input  logic master_enable,
  input  logic txrdy_q,
  output logic tc_set,
  output logic tc_clr,
  output logic tr_set,
  output logic tr_clr
);
  logic m_tc_set, s_tc_set;

  always_comb begin
    m_tc_set = nack_seen | (stop_sent & txrdy_q & shift_empty);
    s_tc_set = bus_stop | bus_rstart_foreign;
    tc_set   = is_master ? m_tc_set : s_tc_set;
    tc_clr   = bus_start;
    tr_set   = (is_master & hold_to_shift) | nack_seen | master_enable;
    tr_clr   = is_master & thr_write;
  end
endmodule

// File: rtl/twsf_status.sv
module twsf_status
  import twsf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              is_master,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              bus_rstart_foreign,
  input  logic              hold_to_shift,
  input  logic              byte_rcvd,
  input  logic              nack_seen,
  input  logic              stop_sent,
  input  logic              shift_empty,
  input  logic              thr_write,
  input  logic              rhr_read,
  input  logic              sr_read,
  input  logic              master_enable,
  output logic [STAT_W-1:0] status
);
  logic tc_q, rx_q, tr_q, nk_q;
  logic tc_set, tc_clr, tr_set, tr_clr;

  twsf_txcomp_rules u_rules (
    .is_master          (is_master),
    .bus_start          (bus_start),
    .bus_stop           (bus_stop),
    .bus_rstart_foreign (bus_rstart_foreign),
    .hold_to_shift      (hold_to_shift),
    .nack_seen          (nack_seen),
    .stop_sent          (stop_sent),
    .shift_empty        (shift_empty),
    .thr_write          (thr_write),
    .master_enable      (master_enable),
    .txrdy_q            (tr_q),
    .tc_set             (tc_set),
    .tc_clr             (tc_clr),
    .tr_set             (tr_set),
    .tr_clr             (tr_clr)
  );

  twsf_flag #(.RST_VAL(RESET_WORD[TC_BIT])) u_tc (
    .clk(clk), .rst(rst), .set_i(tc_set), .clr_i(tc_clr), .q(tc_q));
  twsf_flag #(.RST_VAL(RESET_WORD[RX_BIT])) u_rx (
    .clk(clk), .rst(rst), .set_i(byte_rcvd), .clr_i(rhr_read), .q(rx_q));
  twsf_flag #(.RST_VAL(RESET_WORD[TR_BIT])) u_tr (
    .clk(clk), .rst(rst), .set_i(tr_set), .clr_i(tr_clr), .q(tr_q));
  twsf_flag #(.RST_VAL(RESET_WORD[NK_BIT])) u_nk (
    .clk(clk), .rst(rst), .set_i(nack_seen), .clr_i(sr_read), .q(nk_q));

  always_comb begin
    status         = RESET_WORD & ~OWNED_MASK;
    status[TC_BIT] = tc_q;
    status[RX_BIT] = rx_q;
    status[TR_BIT] = tr_q;
    status[NK_BIT] = nk_q;
  end
endmodule

// File: rtl/twsf_status_chk.sv
module twsf_status_chk
  import twsf_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              is_master,
  input logic              bus_start,
  input logic              bus_stop,
  input logic              bus_rstart_foreign,
  input logic              hold_to_shift,
  input logic              byte_rcvd,
  input logic              nack_seen,
  input logic              stop_sent,
  input logic              shift_empty,
  input logic              thr_write,
  input logic              rhr_read,
  input logic              sr_read,
  input logic              master_enable,
  input logic [STAT_W-1:0] status
);
  p_reset_r1: assert property (@(posedge clk) rst |=> status == RESET_WORD);
  p_slave_start_r4: assert property (@(posedge clk) disable iff (rst)
    !is_master && bus_start && !bus_stop && !bus_rstart_foreign |=> !status[TC_BIT]);
  p_slave_end_r5: assert property (@(posedge clk) disable iff (rst)
    !is_master && (bus_stop || bus_rstart_foreign) |=> status[TC_BIT]);
  p_rx_set_r6: assert property (@(posedge clk) disable iff (rst)
    byte_rcvd |=> status[RX_BIT]);
  p_rx_clr_r6: assert property (@(posedge clk) disable iff (rst)
    rhr_read && !byte_rcvd |=> !status[RX_BIT]);
  p_thr_clr_r7: assert property (@(posedge clk) disable iff (rst)
    is_master && thr_write && !hold_to_shift && !nack_seen && !master_enable |=> !status[TR_BIT]);
  p_nack_r8: assert property (@(posedge clk) disable iff (rst)
    nack_seen && is_master |=> status[TC_BIT] && status[TR_BIT] && status[NK_BIT]);
  p_enable_r9: assert property (@(posedge clk) disable iff (rst)
    master_enable |=> status[TR_BIT]);
  p_nk_clr_r10: assert property (@(posedge clk) disable iff (rst)
    sr_read && !nack_seen |=> !status[NK_BIT]);
  p_slave_tr_r11: assert property (@(posedge clk) disable iff (rst)
    !is_master && !nack_seen && !master_enable |=> $stable(status[TR_BIT]));
endmodule

bind twsf_status twsf_status_chk u_chk (.*);

// File: tb/tb_twsf_status.sv
module tb_twsf_status;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic is_master = 1'b1;
  logic bus_start = 0, bus_stop = 0, bus_rstart_foreign = 0, hold_to_shift = 0;
  logic byte_rcvd = 0, nack_seen = 0, stop_sent = 0, shift_empty = 0;
  logic thr_write = 0, rhr_read = 0, sr_read = 0, master_enable = 0;
  logic [31:0] status;
  int total = 0, bad = 0;
  bit exp_tc = 1, exp_rx = 0, exp_tr = 0, exp_nk = 0;

  always #5 clk = ~clk;

  twsf_status dut (.*);

  task automatic idle();
    bus_start = 0; bus_stop = 0; bus_rstart_foreign = 0; hold_to_shift = 0;
    byte_rcvd = 0; nack_seen = 0; stop_sent = 0; thr_write = 0;
    rhr_read = 0; sr_read = 0; master_enable = 0;
  endtask

  // inputs are driven 2 ns after an edge; the next edge samples them
  task automatic tick();
    @(posedge clk); #2;
    idle();
  endtask

  task automatic check(string req);
    logic [31:0] exp;
    exp = 32'h0000_F008 | 32'(exp_tc) | (32'(exp_rx) << 1) | (32'(exp_tr) << 2) | (32'(exp_nk) << 8);
    total++;
    if (status !== exp) begin
      bad++;
      $display("FAIL %s: status=%h expected=%h", req, status, exp);
    end
  endtask

  task automatic t_reset();
    check("R1 reset word");
  endtask

  task automatic t_enable();
    is_master = 1; master_enable = 1; tick();
    exp_tr = 1; check("R9 enable sets txrdy");
  endtask

  task automatic t_master_frame();
    bus_start = 1; tick(); exp_tc = 0; check("R2 start clears txcomp");
    thr_write = 1; tick(); exp_tr = 0; check("R7 thr write clears txrdy");
    stop_sent = 1; shift_empty = 1; tick(); check("R3 stop-sent with holding full");
    hold_to_shift = 1; tick(); exp_tr = 1; check("R7 move sets txrdy");
    thr_write = 1; hold_to_shift = 1; tick(); check("R7 set wins");
    shift_empty = 0; stop_sent = 1; tick(); check("R3 stop-sent with shifter busy");
    sr_read = 1; tick(); check("R10 status read side effects");
    shift_empty = 1; stop_sent = 1; tick(); exp_tc = 1; check("R3 stop-sent completes");
    bus_start = 1; tick(); exp_tc = 0; check("R2 new frame");
    bus_stop = 1; tick(); check("R11 master ignores bus stop");
    bus_rstart_foreign = 1; tick(); check("R11 master ignores foreign rstart");
  endtask

  task automatic t_nack();
    is_master = 1;
    thr_write = 1; tick(); exp_tr = 0; check("R7 thr write");
    nack_seen = 1; tick(); exp_tc = 1; exp_tr = 1; exp_nk = 1; check("R8 nack sets three flags");
    sr_read = 1; tick(); exp_nk = 0; check("R10 status read clears nack");
    nack_seen = 1; sr_read = 1; tick(); exp_nk = 1; check("R10 nack set wins over read");
    sr_read = 1; tick(); exp_nk = 0; check("R10 clear again");
  endtask

  task automatic t_rx();
    byte_rcvd = 1; tick(); exp_rx = 1; check("R6 byte sets rxrdy");
    sr_read = 1; tick(); check("R10 status read keeps rxrdy");
    rhr_read = 1; tick(); exp_rx = 0; check("R6 read clears rxrdy");
    rhr_read = 1; byte_rcvd = 1; tick(); exp_rx = 1; check("R6 set wins");
    rhr_read = 1; tick(); exp_rx = 0; check("R6 cleared");
  endtask

  task automatic t_slave();
    is_master = 0; #1;
    bus_start = 1; tick(); exp_tc = 0; check("R4 slave start clears txcomp");
    thr_write = 1; tick(); check("R11 slave thr write ignored");
    bus_stop = 1; tick(); exp_tc = 1; check("R5 slave stop sets txcomp");
    bus_start = 1; tick(); exp_tc = 0; check("R4 start again");
    bus_rstart_foreign = 1; tick(); exp_tc = 1; check("R5 foreign rstart sets txcomp");
    bus_start = 1; bus_stop = 1; tick(); check("R5 set wins over start");
    bus_start = 1; tick(); exp_tc = 0; check("R4 start");
    stop_sent = 1; shift_empty = 1; tick(); check("R11 slave ignores stop-sent");
    master_enable = 1; tick(); check("R9 enable in slave keeps txrdy high");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        t_reset();
        t_enable();
        t_master_frame();
        t_nack();
        t_rx();
        t_slave();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule